// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction should trap. It receives two operands and a five-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. The trap fires when at least one enabled relation holds. A mode input chooses between a word compare and a doubleword compare. The word compare uses only the low 32 bits of each operand, and the doubleword compare uses all 64 bits.

A request is presented for one cycle with `in_valid` high. In the next cycle the unit presents a registered result. The result carries a trap flag and an exception cause/sub-code pair. When the trap fires, the pair names a program-class exception with the trap sub-code. Requests may arrive back to back. Control is a two-state machine. `ST_IDLE` has no result to show. `ST_REPORT` presents the result of the request accepted in the previous cycle. The transitions are `GO_REPORT` (IDLE to REPORT on a request), `STAY_REPORT` (REPORT to REPORT on a request), `GO_IDLE` (REPORT to IDLE with no request) and `STAY_IDLE` (IDLE to IDLE with no request).

Top module: `trapcmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when `op_a` is less than `op_b` as two's-complement signed values.
- R2: Mask bit 3 (0x08) enables a trap on signed greater-than, and mask bit 2 (0x04) enables a trap on equality.
- R3: Mask bit 1 (0x02) enables a trap on unsigned less-than, and mask bit 0 (0x01) enables a trap on unsigned greater-than.
- R4: The trap fires when the OR of all enabled relations is true. A mask of zero never traps.
- R5: A mask of 0x1F traps for every operand pair and in both modes.
- R6: With `dword_mode` low, only bits 31:0 of each operand are compared, and bit 31 is the sign. Bits 63:32 have no effect on the result.
- R7: With `dword_mode` high, all 64 bits are compared, and bit 63 is the sign.
- R8: When the trap fires, `exc_cause` is 4'h6 (program class) and `exc_subcode` is 4'h2 (trap). When the trap does not fire, both are 4'h0.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and back-to-back requests produce back-to-back results. When `out_valid` is low, `trap_hit`, `exc_cause` and `exc_subcode` are all zero.
- R10: While reset is active, and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operands and mask are sampled on this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond_mask | input | 5 | Relation enables: bit4 slt, bit3 sgt, bit2 eq, bit1 ult, bit0 ugt |
| dword_mode | input | 1 | 1 selects the 64-bit compare, 0 selects the 32-bit compare |
| out_valid | output | 1 | Result present |
| trap_hit | output | 1 | Trap condition met |
| exc_cause | output | 4 | Exception class (4'h6 program, 4'h0 none) |
| exc_subcode | output | 4 | Program sub-code (4'h2 trap, 4'h0 none) |

## Verification
The bench targets operands whose signed and unsigned orderings disagree, such as 0x80000000 against 0x7FFFFFFF. A design that mixed up the signed and unsigned comparators would trap on exactly these pairs under the wrong mask bit. Word-mode vectors pair equal low halves with different high halves. A unit that leaked bits 63:32 into the compare, or took the sign from bit 63, would then report a trap or a miss wrongly. Back-to-back requests, followed by an idle cycle, check that a result is neither dropped nor held past its single cycle. The zero and all-ones masks are swept over random operands.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
    localparam int REL_N   = 5;
    localparam int REL_SLT = 4;
    localparam int REL_SGT = 3;
    localparam int REL_EQ  = 2;
    localparam int REL_ULT = 1;
    localparam int REL_UGT = 0;

    localparam int CODEW = 4;
    localparam logic [CODEW-1:0] CAUSE_NONE    = 4'h0;
    localparam logic [CODEW-1:0] CAUSE_PROGRAM = 4'h6;
    localparam logic [CODEW-1:0] SUB_NONE      = 4'h0;
    localparam logic [CODEW-1:0] SUB_TRAP      = 4'h2;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } trap_state_e;
endpackage

// File: rtl/trapcmp_relate.sv
module trapcmp_relate
    import trapcmp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic             dword,
    output logic [REL_N-1:0] rel
);
    localparam int EXTW = XLEN + 1;
    localparam int PADW = EXTW - WLEN;

    logic [EXTW-1:0] a_sx, b_sx, a_zx, b_zx;

    // Extend both operands one bit past XLEN so that one signed
    // comparator and one unsigned comparator serve both modes.
    always_comb begin
        if (dword) begin
            a_sx = {a[XLEN-1], a};
            b_sx = {b[XLEN-1], b};
            a_zx = {1'b0, a};
            b_zx = {1'b0, b};
        end else begin
            a_sx = {{PADW{a[WLEN-1]}}, a[WLEN-1:0]};
            b_sx = {{PADW{b[WLEN-1]}}, b[WLEN-1:0]};
            a_zx = {{PADW{1'b0}}, a[WLEN-1:0]};
            b_zx = {{PADW{1'b0}}, b[WLEN-1:0]};
        end
    end

    always_comb begin
        rel          = '0;
        rel[REL_SLT] = $signed(a_sx) < $signed(b_sx);
        rel[REL_SGT] = $signed(a_sx) > $signed(b_sx);
        rel[REL_EQ]  = a_zx == b_zx;
        rel[REL_ULT] = a_zx < b_zx;
        rel[REL_UGT] = a_zx > b_zx;
    end
endmodule

// File: rtl/trapcmp_select.sv
module trapcmp_select
    import trapcmp_pkg::*;
(
    input  logic [REL_N-1:0] rel,
    input  logic [REL_N-1:0] mask,
    output logic             hit
);
    logic [REL_N-1:0] armed;

    for (genvar i = 0; i < REL_N; i++) begin : g_arm
        assign armed[i] = rel[i] & mask[i];
    end

    assign hit = |armed;
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XLEN-1:0]  op_a,
    input  logic [XLEN-1:0]  op_b,
    input  logic [4:0]       cond_mask,
    input  logic             dword_mode,
    output logic             out_valid,
    output logic             trap_hit,
    output logic [3:0]       exc_cause,
    output logic [3:0]       exc_subcode
);
    trap_state_e      state_q, state_d;
    logic [REL_N-1:0] rel;
    logic             hit;

    trapcmp_relate #(.XLEN(XLEN), .WLEN(WLEN)) u_relate (
        .a     (op_a),
        .b     (op_b),
        .dword (dword_mode),
        .rel   (rel)
    );

    trapcmp_select u_select (
        .rel  (rel),
        .mask (cond_mask),
        .hit  (hit)
    );

    // Next state: GO_REPORT / STAY_REPORT on a request, GO_IDLE / STAY_IDLE otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_d == ST_IDLE) begin
            trap_hit    <= 1'b0;
            exc_cause   <= CAUSE_NONE;
            exc_subcode <= SUB_NONE;
        end else begin
            trap_hit    <= hit;
            exc_cause   <= hit ? CAUSE_PROGRAM : CAUSE_NONE;
            exc_subcode <= hit ? SUB_TRAP : SUB_NONE;
        end
    end

    assign out_valid = (state_q == ST_REPORT);
endmodule

// File: rtl/trapcmp_chk.sv
module trapcmp_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] op_b,
    input logic [4:0]      cond_mask,
    input logic            dword_mode,
    input logic            out_valid,
    input logic            trap_hit,
    input logic [3:0]      exc_cause,
    input logic [3:0]      exc_subcode
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R9
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!trap_hit && exc_cause == 4'h0 && exc_subcode == 4'h0)); // R9
    AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == 5'h00) |=> !trap_hit); // R4
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond_mask == 5'h1F) |=> trap_hit); // R5
    AST_EQ_DWORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dword_mode && cond_mask == 5'h04 && op_a == op_b) |=> trap_hit); // R2
    AST_CAUSE_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_hit |-> (exc_cause == 4'h6 && exc_subcode == 4'h2)); // R8
    AST_CAUSE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_hit |-> (exc_cause == 4'h0 && exc_subcode == 4'h0)); // R8
endmodule

bind trapcmp_unit trapcmp_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_a        (op_a),
    .op_b        (op_b),
    .cond_mask   (cond_mask),
    .dword_mode  (dword_mode),
    .out_valid   (out_valid),
    .trap_hit    (trap_hit),
    .exc_cause   (exc_cause),
    .exc_subcode (exc_subcode)
);

// File: tb/trapcmp_unit_tb.sv
`timescale 1ns/1ps
module trapcmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [4:0]  cond_mask = '0;
    logic        dword_mode = 1'b0;
    logic        out_valid, trap_hit;
    logic [3:0]  exc_cause, exc_subcode;

    int vectors = 0;
    int fails   = 0;
    bit armed   = 1'b0;
    bit done    = 1'b0;
    string cur_tag = "R10";

    logic  exp_valid = 1'b0, exp_trap = 1'b0;
    string exp_tag = "R10";

    always #2 clk = ~clk;

    trapcmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .cond_mask(cond_mask), .dword_mode(dword_mode), .out_valid(out_valid),
        .trap_hit(trap_hit), .exc_cause(exc_cause), .exc_subcode(exc_subcode)
    );

    function automatic bit ref_trap(logic [63:0] a, logic [63:0] b, logic [4:0] m, logic dw);
        longint sa, sb;
        longint unsigned ua, ub;
        int wsa, wsb;
        int unsigned wua, wub;
        bit lt_s, gt_s, eq, lt_u, gt_u;
        if (dw) begin
            sa = a; sb = b; ua = a; ub = b;
            lt_s = sa < sb; gt_s = sa > sb; eq = ua == ub;
            lt_u = ua < ub; gt_u = ua > ub;
        end else begin
            wsa = a[31:0]; wsb = b[31:0]; wua = a[31:0]; wub = b[31:0];
            lt_s = wsa < wsb; gt_s = wsa > wsb; eq = wua == wub;
            lt_u = wua < wub; gt_u = wua > wub;
        end
        return (m[4] && lt_s) || (m[3] && gt_s) || (m[2] && eq) ||
               (m[1] && lt_u) || (m[0] && gt_u);
    endfunction

    // Reference model: one result per accepted request, shown for one cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0; exp_trap <= 1'b0; exp_tag <= "R10";
        end else if (in_valid) begin
            exp_valid <= 1'b1;
            exp_trap  <= ref_trap(op_a, op_b, cond_mask, dword_mode);
            exp_tag   <= cur_tag;
        end else begin
            exp_valid <= 1'b0; exp_trap <= 1'b0; exp_tag <= "R9";
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            logic [3:0] ec, es;
            ec = exp_trap ? 4'h6 : 4'h0;
            es = exp_trap ? 4'h2 : 4'h0;
            vectors++;
            if (out_valid !== exp_valid || trap_hit !== exp_trap ||
                exc_cause !== ec || exc_subcode !== es) begin
                fails++;
                $display("FAIL %s: got v=%0b t=%0b c=%h s=%h expected v=%0b t=%0b c=%h s=%h",
                         exp_tag, out_valid, trap_hit, exc_cause, exc_subcode,
                         exp_valid, exp_trap, ec, es);
            end
        end
    end

    task automatic drive(input logic [63:0] a, input logic [63:0] b,
                         input logic [4:0] m, input logic dw, input string tag);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; cond_mask = m; dword_mode = dw; cur_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; cur_tag = "R9";
    endtask

    initial begin
        armed = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 signed less-than, signed vs unsigned disagreement
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h10, 1'b1, "R1");
        drive(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h10, 1'b1, "R1");
        // R2 signed greater-than and equal
        drive(64'h5, 64'h8000_0000_0000_0000, 5'h08, 1'b1, "R2");
        drive(64'h1234, 64'h1234, 5'h04, 1'b1, "R2");
        drive(64'h1234, 64'h1235, 5'h04, 1'b1, "R2");
        idle();
        // R3 unsigned relations
        drive(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, "R3");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01, 1'b1, "R3");
        drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h02, 1'b1, "R3");
        // R6 word mode: sign from bit 31, upper half ignored
        drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h10, 1'b0, "R6");
        drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h01, 1'b0, "R6");
        drive(64'hAAAA_5555_0000_0042, 64'h1234_0000_0000_0042, 5'h04, 1'b0, "R6");
        drive(64'h7FFF_FFFF_0000_0001, 64'h0000_0000_0000_0002, 5'h08, 1'b0, "R6");
        // R7 same pattern in doubleword mode differs
        drive(64'hAAAA_5555_0000_0042, 64'h1234_0000_0000_0042, 5'h04, 1'b1, "R7");
        drive(64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 5'h10, 1'b1, "R7");
        idle(); idle();
        // R4 OR of relations; R5 all ones; R8 cause pair; random sweep
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
            if (i % 5 == 0) rb[31:0] = ra[31:0];
            case (i % 4)
                0: drive(ra, rb, 5'h00, i[3], "R4");
                1: drive(ra, rb, 5'h1F, i[3], "R5");
                default: drive(ra, rb, 5'($urandom), i[3], "R8");
            endcase
            if (i % 9 == 0) idle();
        end
        idle(); idle();
        // R10 reset mid-stream clears the result
        drive(64'h1, 64'h1, 5'h04, 1'b1, "R10");
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; cur_tag = "R10";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(); idle();
        @(negedge clk);
        armed = 1'b0;
        done  = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule